// File: doc/BRIEF.md
# Direct-Mapped Word-Sectored Cache Controller

This block sits between a 16-bit processor bus and a slower main memory and keeps a direct-mapped cache of recently used words. Each cache line holds four 16-bit words under one tag. Validity is tracked per word rather than per line, so a line can be partly filled. The tag store compares the stored tag with the incoming tag and yields the hit decision in the same cycle.

A read that hits is answered in the request cycle and does not touch main memory. A read that misses fetches only the addressed word. If the line already carries the same tag, the other words keep their state. If the tag differs, the line is retagged and only the fetched word is left valid. Writes are write-through with no allocation. A write hit updates the enabled byte lanes in the cache, and every write goes to memory.

A flush input invalidates the whole cache. It clears one line index per cycle and stalls the processor while it runs. The geometry is fixed when the block is built: `INDEX_W` sets the number of lines, and the full 64 KB organisation (8K lines of 8 bytes) is obtained with `INDEX_W = 13`. Nothing can be reconfigured at run time.

Top module: `sector_cache`

## Requirements
- R1: While reset is low, `cpu_ready` and `mem_req` are low. After reset every word is invalid, so the first read of any address misses.
- R2: The processor address is split as follows. Bit 0 is the byte lane and is ignored for lookup. Bits 2:1 select the word in the line. The next `INDEX_W` bits (10:3 by default) select the line. The remaining upper bits (23:11 by default) are the tag. Addresses that differ only in bit 0 hit the same word, and lines at other indexes are unaffected by a fill.
- R3: A read whose tag matches and whose word is valid raises `cpu_ready` in the request cycle with the cached data on `cpu_rdata`. `mem_req` stays low.
- R4: On a read miss, `mem_req` rises in the cycle after the request with `mem_we` low, `mem_be` = 2'b11 and `mem_addr` = `cpu_addr[23:1]`. In the cycle `mem_ack` is high, `cpu_ready` is high and `cpu_rdata` equals `mem_rdata`. That word then hits.
- R5: A read miss on a line whose tag matches marks only the addressed word valid. Words already valid in that line keep hitting.
- R6: A read miss on a line with a different tag retags the line and leaves only the fetched word valid. The other three words of the line then miss.
- R7: Every write is sent to memory with `mem_we` high, `mem_be` = `cpu_be` and `mem_wdata` = `cpu_wdata`. `cpu_ready` rises in the acknowledge cycle. On a write hit, the cache byte lanes enabled by `cpu_be` are updated: bit 0 covers data bits 7:0 and bit 1 covers bits 15:8.
- R8: A write miss changes no cache state. A later read of that address misses and returns the memory value.
- R9: `mem_req` stays high, and `cpu_ready` stays low, until the cycle `mem_ack` is seen.
- R10: A flush seen in an idle cycle takes priority over a request in that cycle. It is followed by one cycle per line index (`2**INDEX_W`) in which `cpu_ready` and `mem_req` are low. After the flush every word is invalid. A flush pulse seen while a memory access is in progress is held, and the flush starts right after that access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate-all request |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | Processor byte address |
| cpu_be | input | 2 | Byte-lane enables for writes |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid when `cpu_ready` is high on a read |
| cpu_ready | output | 1 | Access complete |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 23 | Memory word address |
| mem_be | output | 2 | Memory byte enables |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory access done, read data valid |
| mem_rdata | input | 16 | Memory read data |

## Verification
A read hit is due in the request cycle itself. A miss or a write shows `mem_req` one cycle later and completes in the cycle the bench raises `mem_ack`. A flush adds one idle decision cycle plus `2**INDEX_W` stall cycles before a held request reaches memory. The bench drives inputs at the falling edge, samples one time unit later in that same cycle, and compares every cycle of every access against a behavioural word map, so an early or late `cpu_ready` or `mem_req` is flagged in the exact cycle. The stall count for both a direct flush and a flush held across a memory access comes from that same cycle accounting.

// File: rtl/sector_cache.sv
module sector_cache #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int WORD_SEL_W = 2,
  parameter int INDEX_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W/8-1:0]     cpu_be,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_ready,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-2:0]       mem_addr,
  output logic [DATA_W/8-1:0]     mem_be,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  input  logic [DATA_W-1:0]       mem_rdata
);
  localparam int BE_W  = DATA_W / 8;
  localparam int OFF_W = $clog2(BE_W);
  localparam int WPL   = 1 << WORD_SEL_W;
  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - OFF_W - WORD_SEL_W - INDEX_W;

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_FLUSH} state_t;

  state_t             state;
  logic [INDEX_W-1:0] fl_cnt;
  logic               flush_pend;
  logic [TAG_W-1:0]   tag_mem [LINES];
  logic [WPL-1:0]     vld     [LINES];
  logic [DATA_W-1:0]  dat     [LINES*WPL];

  wire [WORD_SEL_W-1:0]         wsel = cpu_addr[OFF_W +: WORD_SEL_W];
  wire [INDEX_W-1:0]            idx  = cpu_addr[OFF_W+WORD_SEL_W +: INDEX_W];
  wire [TAG_W-1:0]              tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [INDEX_W+WORD_SEL_W-1:0] slot = {idx, wsel};
  wire                          unused_lane = cpu_addr[0];

  wire tag_eq   = (tag_mem[idx] == tag);
  wire hit      = tag_eq && vld[idx][wsel];
  wire flush_go = flush || flush_pend;
  wire rd_hit   = (state == S_IDLE) && !flush_go && cpu_req && !cpu_we && hit;
  wire mem_done = (state == S_MEM) && mem_ack;

  assign cpu_ready = rd_hit || mem_done;
  assign cpu_rdata = mem_done ? mem_rdata : dat[slot];
  assign mem_req   = (state == S_MEM);
  assign mem_we    = cpu_we;
  assign mem_addr  = cpu_addr[ADDR_W-1:OFF_W];
  assign mem_be    = cpu_we ? cpu_be : '1;
  assign mem_wdata = cpu_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      fl_cnt     <= '0;
      flush_pend <= 1'b0;
      for (int i = 0; i < LINES; i++) vld[i] <= '0;
    end else begin
      flush_pend <= (state == S_IDLE) ? 1'b0 : (flush_pend || flush);
      case (state)
        S_IDLE: begin
          if (flush_go) begin
            state  <= S_FLUSH;
            fl_cnt <= '0;
          end else if (cpu_req && (cpu_we || !hit)) begin
            state <= S_MEM;
          end
        end
        S_MEM: begin
          if (mem_ack) begin
            state <= S_IDLE;
            if (!cpu_we) begin
              if (tag_eq) vld[idx][wsel] <= 1'b1;
              else        vld[idx]       <= WPL'(1) << wsel;
            end
          end
        end
        S_FLUSH: begin
          vld[fl_cnt] <= '0;
          fl_cnt      <= fl_cnt + 1'b1;
          if (&fl_cnt) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mem_done) begin
      if (!cpu_we) begin
        dat[slot] <= mem_rdata;
        if (!tag_eq) tag_mem[idx] <= tag;
      end else if (hit) begin
        for (int b = 0; b < BE_W; b++)
          if (cpu_be[b]) dat[slot][8*b +: 8] <= cpu_wdata[8*b +: 8];
      end
    end
  end

  // R4: a finished read fill leaves the word valid under the new tag
  a_r4_fill_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_done && !cpu_we) |=> vld[$past(idx)][$past(wsel)] && (tag_mem[$past(idx)] == $past(tag)));

  // R6: a retagging fill leaves exactly one valid word
  a_r6_retag_single: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_done && !cpu_we && !tag_eq) |=> ($countones(vld[$past(idx)]) == 1));

  // R8: a write miss leaves the line's valid bits untouched
  a_r8_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_done && cpu_we && !hit) |=> (vld[$past(idx)] == $past(vld[idx])));

  // R9: the memory request is held until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);

  // R10: each flush cycle clears the line it visits
  a_r10_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FLUSH) |=> (vld[$past(fl_cnt)] == '0));

  // R10: a flush pulse seen during a memory access is remembered
  a_r10_flush_latched: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_MEM) && flush) |=> flush_pend);
endmodule

// File: tb/sector_cache_tb.sv
module sector_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int INDEX_W    = 8;
  localparam int LINES      = 1 << INDEX_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [1:0]  cpu_be = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req;
  logic        mem_we;
  logic [22:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  logic [15:0] mem_m   [int];
  logic [15:0] cache_m [int];
  int          ltag    [int];

  sector_cache #(.INDEX_W(INDEX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mem_rd(int wa);
    if (mem_m.exists(wa)) return mem_m[wa];
    return 16'(wa * 7 + 3) ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] merge(logic [15:0] old, logic [1:0] be, logic [15:0] wd);
    logic [15:0] n = old;
    if (be[0]) n[7:0]  = wd[7:0];
    if (be[1]) n[15:8] = wd[15:8];
    return n;
  endfunction

  task automatic access(bit we, logic [23:0] a, logic [1:0] be, logic [15:0] wd,
                        int lat, int stall, bit fl_now, bit fl_mid, string req);
    int  wa  = int'(a[23:1]);
    int  idx = int'(a[10:3]);
    int  tg  = int'(a[23:11]);
    bit  hit;
    if (fl_now) cache_m.delete();
    hit = !we && cache_m.exists(wa);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
    flush = fl_now;
    #1;
    chk(req, "ready in request cycle", {31'd0, cpu_ready}, {31'd0, hit});
    chk(req, "no mem_req in request cycle", {31'd0, mem_req}, 32'd0);
    if (hit) chk(req, "hit data", {16'd0, cpu_rdata}, {16'd0, cache_m[wa]});
    if (!hit) begin
      for (int s = 1; s <= stall; s++) begin
        @(negedge clk);
        flush = 1'b0;
        #1;
        if (cpu_ready !== 1'b0 || mem_req !== 1'b0)
          chk(req, "stall cycle ready/mem_req", {30'd0, cpu_ready, mem_req}, 32'd0);
      end
      if (stall > 0) chk(req, "stall ended quiet", {30'd0, cpu_ready, mem_req}, 32'd0);
      for (int k = 1; k <= lat; k++) begin
        @(negedge clk);
        flush = fl_mid && (k == 1);
        if (k == lat) begin
          mem_ack = 1'b1;
          mem_rdata = mem_rd(wa);
        end
        #1;
        chk(req, "mem_req held", {31'd0, mem_req}, 32'd1);
        chk(req, "ready only on ack", {31'd0, cpu_ready}, {31'd0, k == lat});
        if (k == 1) begin
          chk(req, "mem_we", {31'd0, mem_we}, {31'd0, we});
          chk(req, "mem_addr", {9'd0, mem_addr}, {9'd0, a[23:1]});
          chk(req, "mem_be", {30'd0, mem_be}, {30'd0, (we ? be : 2'b11)});
          if (we) chk(req, "mem_wdata", {16'd0, mem_wdata}, {16'd0, wd});
        end
        if (k == lat && !we) chk(req, "miss data", {16'd0, cpu_rdata}, {16'd0, mem_rd(wa)});
      end
      if (we) begin
        mem_m[wa] = merge(mem_rd(wa), be, wd);
        if (cache_m.exists(wa)) cache_m[wa] = merge(cache_m[wa], be, wd);
      end else begin
        if (ltag.exists(idx) && ltag[idx] != tg)
          for (int w = 0; w < 4; w++) cache_m.delete(((ltag[idx] << INDEX_W | idx) << 2) | w);
        ltag[idx] = tg;
        cache_m[wa] = mem_rd(wa);
      end
      if (fl_mid) cache_m.delete();
    end
    @(negedge clk);
    cpu_req = 1'b0; mem_ack = 1'b0; flush = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] a = 24'h001000;
    logic [23:0] b = 24'h001800;
    logic [23:0] c = 24'h123456;
    cpu_req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1", "ready in reset", {31'd0, cpu_ready}, 32'd0);
    chk("R1", "mem_req in reset", {31'd0, mem_req}, 32'd0);
    cpu_req = 1'b0;
    rst_n = 1'b1;

    access(0, a,         2'b11, 16'h0, 1, 0, 0, 0, "R1");
    access(0, a,         2'b11, 16'h0, 1, 0, 0, 0, "R3");
    access(0, a | 24'h1, 2'b11, 16'h0, 1, 0, 0, 0, "R2");
    access(0, a + 24'h2, 2'b11, 16'h0, 3, 0, 0, 0, "R5");
    access(0, a,         2'b11, 16'h0, 1, 0, 0, 0, "R5");
    access(0, a + 24'h8, 2'b11, 16'h0, 2, 0, 0, 0, "R2");
    access(0, a,         2'b11, 16'h0, 1, 0, 0, 0, "R2");
    access(0, b,         2'b11, 16'h0, 2, 0, 0, 0, "R6");
    access(0, a + 24'h2, 2'b11, 16'h0, 1, 0, 0, 0, "R6");
    access(0, b,         2'b11, 16'h0, 1, 0, 0, 0, "R6");
    access(0, b,         2'b11, 16'h0, 1, 0, 0, 0, "R3");
    access(1, b,         2'b01, 16'h12EF, 2, 0, 0, 0, "R7");
    access(0, b,         2'b11, 16'h0, 1, 0, 0, 0, "R7");
    access(1, b,         2'b10, 16'hC4D5, 1, 0, 0, 0, "R7");
    access(0, b,         2'b11, 16'h0, 1, 0, 0, 0, "R7");
    access(1, c,         2'b11, 16'hBEEF, 2, 0, 0, 0, "R8");
    access(0, c,         2'b11, 16'h0, 1, 0, 0, 0, "R8");
    access(0, 24'hFFFFFE, 2'b11, 16'h0, 5, 0, 0, 0, "R9");
    access(0, b,         2'b11, 16'h0, 1, LINES + 1, 1, 0, "R10");
    access(0, 24'h000010, 2'b11, 16'h0, 3, 0, 0, 1, "R10");
    access(0, 24'h000010, 2'b11, 16'h0, 1, LINES, 0, 0, "R10");
    access(0, 24'h000010, 2'b11, 16'h0, 1, 0, 0, 0, "R3");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule